// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the chain of extended capability headers kept in a function's configuration space, from byte offset 0x100 up to 0xFFF. The space lives in an external RAM with one 32-bit word per address and one cycle of read latency, and the block drives that RAM's read and write ports itself. A lookup follows the chain of next pointers until it finds the requested 16-bit capability ID or runs off the end. It returns the byte offset of the matching header and the byte offset of the header visited just before it.

An append operation adds a new header to the chain. When the new offset is 0x100, the head word is rewritten and the next pointer already stored there is kept. For any other offset, the walker first finds the current tail, using ID 0 as a value that can never match. It then points the tail's next field at the new offset and writes the new header with an empty next field. Last, it drives a clear strobe over every word of the new region, so that the external write-enable and write-one-to-clear masks make the region read-only.

Each request is started by a one-cycle `start` and finishes with a one-cycle `done`. A corrupt chain, whether a pointer outside the legal window or a loop, ends in an error and cannot hang the block.

Top module: `ecap_walker`

## Requirements
- R1: A header word carries the capability ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A byte offset maps to RAM word address offset>>2, and every walk begins with the header at byte offset 0x100.
- R2: A lookup for a nonzero ID that matches a header returns `hit_off` = that header's offset and `prev_off` = the offset visited before it, which is 0 when the match is the first header.
- R3: If the word at 0x100 is entirely zero, a lookup returns `hit_off` = 0 and `prev_off` = 0 without error.
- R4: A lookup that reaches a next field of 0 with no match returns `hit_off` = 0 and `prev_off` = the last visited offset. ID 0 never matches, so a lookup for ID 0 returns the tail in `prev_off`.
- R5: A nonzero next field below 0x100 or above 0xFF8 ends the operation with `err` and causes no further reads. The RAM is only ever read inside that window.
- R6: The walker reads at most MAX_HOPS (default 1024) headers per operation. A chain still not ended after that many reads ends with `err`.
- R7: Each visited header costs one read cycle and one compare cycle. A lookup that reads h headers raises `done` exactly 1+2h cycles after the clock edge that samples `start`, and `done` and `err` are each high for one cycle only.
- R8: An append at offset 0x100 writes {old next field of 0x100, new version, new ID} to 0x100 and returns `hit_off` = 0x100, `prev_off` = 0.
- R9: An append at any other offset rewrites the tail header so that only its next field changes, to the new offset, which is 4-byte aligned. It then writes {0, version, ID} at the new offset and returns `hit_off` = new offset, `prev_off` = old tail.
- R10: After its header writes, an accepted append pulses `mask_clr` on ceil(size/4) consecutive word addresses starting at the new offset>>2, one per cycle. `done` follows the last pulse: at 4+n cycles for an append at 0x100, and at 2h+3+n cycles for an append elsewhere, where h is the number of headers read.
- R11: An append with an unaligned offset, an offset outside 0x100..0xFF8, or a size below 8 bytes ends with `err` after one cycle. An append elsewhere than 0x100 into an empty chain ends with `err` after three cycles. Neither case writes to the RAM or the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, sampled when idle |
| op_append | input | 1 | 1 = append, 0 = lookup |
| req_id | input | 16 | ID to look up, or ID of the new header |
| new_ver | input | 4 | Version of the new header |
| new_off | input | 12 | Byte offset of the new header |
| new_size | input | 13 | Byte size of the new region |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error, valid with `done` |
| hit_off | output | 12 | Matching or appended offset, 0 if none |
| prev_off | output | 12 | Previously visited offset or old tail |
| mem_rd | output | 1 | RAM read enable |
| mem_wr | output | 1 | RAM write enable |
| mem_addr | output | 10 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after `mem_rd` |
| mask_clr | output | 1 | Clear both access masks of one word |
| mask_addr | output | 10 | Word address for `mask_clr` |

## Verification
The bench targets the places where a walker usually goes wrong. It looks up the first header, which has no predecessor, and checks that `prev_off` is 0 rather than stale. It looks up ID 0, which a design that lets zero match would stop on too early. On an empty chain, a design that mishandles it would report 0x100 as the tail or append through a nonexistent tail. It also appends at 0x100 over a live chain, where dropping the stored next pointer would cut off every later header. Corrupt chains are built by poking the RAM: a pointer below 0x100, a pointer beyond 0xFF8, and a loop. Without the window or hop limit these would read outside the space or never raise `done`. After every operation, the RAM and mask images are compared word by word with the model, so a tail rewrite that clobbers the ID or version, or a mask sweep of the wrong length, shows up.

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter int OFF_W    = 12,
  parameter int ID_W     = 16,
  parameter int VER_W    = 4,
  parameter int SIZE_W   = 13,
  parameter int BASE_OFF = 256,
  parameter int MAX_HOPS = 1024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          op_append,
  input  logic [ID_W-1:0]               req_id,
  input  logic [VER_W-1:0]              new_ver,
  input  logic [OFF_W-1:0]              new_off,
  input  logic [SIZE_W-1:0]             new_size,
  output logic                          done,
  output logic                          err,
  output logic [OFF_W-1:0]              hit_off,
  output logic [OFF_W-1:0]              prev_off,
  output logic                          mem_rd,
  output logic                          mem_wr,
  output logic [OFF_W-3:0]              mem_addr,
  output logic [ID_W+VER_W+OFF_W-1:0]   mem_wdata,
  input  logic [ID_W+VER_W+OFF_W-1:0]   mem_rdata,
  output logic                          mask_clr,
  output logic [OFF_W-3:0]              mask_addr
);
  localparam int WA_W  = OFF_W - 2;
  localparam int NX_LO = ID_W + VER_W;
  localparam int DW    = NX_LO + OFF_W;
  localparam int NW_W  = SIZE_W - 1;
  localparam int HOP_W = $clog2(MAX_HOPS + 1);
  localparam logic [OFF_W-1:0]  BASE  = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0]  LIMIT = OFF_W'((1 << OFF_W) - 8);
  localparam logic [SIZE_W-1:0] MIN_SZ = SIZE_W'(8);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CMP, S_WTAIL, S_WNEW, S_MCLR} st_t;

  st_t               st;
  logic              app_q;
  logic [ID_W-1:0]   id_q;
  logic [VER_W-1:0]  ver_q;
  logic [OFF_W-1:0]  off_q, cur, prv, keep_nx;
  logic [NW_W-1:0]   nw_q, wcnt;
  logic [HOP_W-1:0]  hops;
  logic [NX_LO-1:0]  tail_lo;

  logic [OFF_W-1:0] hdr_nx;
  logic [ID_W-1:0]  hdr_id;
  logic [SIZE_W:0]  sz_up;
  logic             hit, nx_bad, req_bad, at_limit;

  assign hdr_nx   = mem_rdata[DW-1:NX_LO];
  assign hdr_id   = mem_rdata[ID_W-1:0];
  assign hit      = !app_q && (id_q != '0) && (hdr_id == id_q);
  assign nx_bad   = (hdr_nx < BASE) || (hdr_nx > LIMIT);
  assign at_limit = (hops == HOP_W'(MAX_HOPS - 1));
  assign sz_up    = {1'b0, new_size} + (SIZE_W+1)'(3);
  assign req_bad  = (new_off[1:0] != 2'b00) || (new_off < BASE) ||
                    (new_off > LIMIT) || (new_size < MIN_SZ);

  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WTAIL) || (st == S_WNEW);
  assign mask_clr  = (st == S_MCLR);
  assign mask_addr = off_q[OFF_W-1:2] + WA_W'(wcnt);

  always_comb begin
    case (st)
      S_RD:    mem_addr = cur[OFF_W-1:2];
      S_WTAIL: mem_addr = prv[OFF_W-1:2];
      default: mem_addr = off_q[OFF_W-1:2];
    endcase
    if (st == S_WTAIL) mem_wdata = {off_q, tail_lo};
    else               mem_wdata = {keep_nx, ver_q, id_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      done     <= 1'b0;
      err      <= 1'b0;
      hit_off  <= '0;
      prev_off <= '0;
      app_q    <= 1'b0;
      id_q     <= '0;
      ver_q    <= '0;
      off_q    <= '0;
      cur      <= '0;
      prv      <= '0;
      keep_nx  <= '0;
      nw_q     <= '0;
      wcnt     <= '0;
      hops     <= '0;
      tail_lo  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          app_q   <= op_append;
          id_q    <= req_id;
          ver_q   <= new_ver;
          off_q   <= new_off;
          nw_q    <= sz_up[SIZE_W:2];
          cur     <= BASE;
          prv     <= '0;
          hops    <= '0;
          wcnt    <= '0;
          keep_nx <= '0;
          if (op_append && req_bad) begin
            done     <= 1'b1;
            err      <= 1'b1;
            hit_off  <= '0;
            prev_off <= '0;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_CMP;
        S_CMP: begin
          if (app_q && off_q == BASE) begin
            keep_nx  <= hdr_nx;
            prev_off <= '0;
            st       <= S_WNEW;
          end else if (cur == BASE && mem_rdata == '0) begin
            done     <= 1'b1;
            err      <= app_q;
            hit_off  <= '0;
            prev_off <= '0;
            st       <= S_IDLE;
          end else if (hit) begin
            done     <= 1'b1;
            hit_off  <= cur;
            prev_off <= prv;
            st       <= S_IDLE;
          end else if (hdr_nx == '0) begin
            if (app_q) begin
              prv      <= cur;
              tail_lo  <= mem_rdata[NX_LO-1:0];
              prev_off <= cur;
              st       <= S_WTAIL;
            end else begin
              done     <= 1'b1;
              hit_off  <= '0;
              prev_off <= cur;
              st       <= S_IDLE;
            end
          end else if (nx_bad || at_limit) begin
            done     <= 1'b1;
            err      <= 1'b1;
            hit_off  <= '0;
            prev_off <= cur;
            st       <= S_IDLE;
          end else begin
            prv  <= cur;
            cur  <= hdr_nx;
            hops <= hops + 1'b1;
            st   <= S_RD;
          end
        end
        S_WTAIL: st <= S_WNEW;
        S_WNEW: begin
          wcnt <= '0;
          st   <= S_MCLR;
        end
        S_MCLR: begin
          if (wcnt == nw_q - 1'b1) begin
            done    <= 1'b1;
            hit_off <= off_q;
            st      <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ecap_walker_chk #(
  parameter int OFF_W    = 12,
  parameter int DW       = 32,
  parameter int BASE_OFF = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             err,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mask_clr,
  input logic [OFF_W-3:0] mem_addr,
  input logic [DW-1:0]    mem_wdata
);
  localparam logic [OFF_W-3:0] WLO = (OFF_W-2)'(BASE_OFF / 4);
  localparam logic [OFF_W-3:0] WHI = (OFF_W-2)'(((1 << OFF_W) - 8) / 4);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  // R5
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= WLO && mem_addr <= WHI));
  // R9
  next_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[DW-OFF_W+1:DW-OFF_W] == 2'b00));
  // R10
  mask_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_clr) |-> $past(mem_wr));
  // R1
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && (mem_wr || mask_clr)));
endmodule

bind ecap_walker ecap_walker_chk #(
  .OFF_W(OFF_W), .DW(ID_W + VER_W + OFF_W), .BASE_OFF(BASE_OFF)
) i_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mask_clr(mask_clr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_ecap_walker.sv
module test_ecap_walker;
  localparam int MAXH = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, op_append;
  logic [15:0] req_id;
  logic [3:0]  new_ver;
  logic [11:0] new_off;
  logic [12:0] new_size;
  logic        done, err, mem_rd, mem_wr, mask_clr;
  logic [11:0] hit_off, prev_off;
  logic [9:0]  mem_addr, mask_addr;
  logic [31:0] mem_wdata, mem_rdata;

  ecap_walker i_ecap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
    .req_id(req_id), .new_ver(new_ver), .new_off(new_off), .new_size(new_size),
    .done(done), .err(err), .hit_off(hit_off), .prev_off(prev_off),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mask_clr(mask_clr), .mask_addr(mask_addr)
  );

  logic [31:0] mem  [0:1023];
  logic        mbit [0:1023];
  logic        init_all, poke_en;
  logic [9:0]  poke_a;
  logic [31:0] poke_d;

  always @(posedge clk) begin
    if (init_all) begin
      for (int i = 0; i < 1024; i++) begin
        mem[i]  <= '0;
        mbit[i] <= 1'b1;
      end
      mem_rdata <= '0;
    end else begin
      if (poke_en)  mem[poke_a] <= poke_d;
      if (mem_rd)   mem_rdata <= mem[mem_addr];
      if (mem_wr)   mem[mem_addr] <= mem_wdata;
      if (mask_clr) mbit[mask_addr] <= 1'b0;
    end
  end

  logic [31:0] mm [0:1023];
  logic        mk [0:1023];
  int vec = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wipe();
    @(negedge clk); init_all = 1'b1;
    @(negedge clk); init_all = 1'b0;
    for (int i = 0; i < 1024; i++) begin mm[i] = '0; mk[i] = 1'b1; end
  endtask

  task automatic poke(input int boff, input logic [31:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = 10'(boff / 4); poke_d = d;
    @(negedge clk); poke_en = 1'b0;
    mm[boff / 4] = d;
  endtask

  task automatic model_walk(input int id, output int hit, output int prev,
                            output int h, output bit e, output bit empty);
    int cur, nx;
    logic [31:0] hdr;
    cur = 256; prev = 0; h = 0; e = 0; hit = 0; empty = 0;
    if (mm[64] == 0) begin
      h = 1; empty = 1;
      return;
    end
    while (1) begin
      hdr = mm[cur / 4];
      h++;
      nx = int'(hdr[31:20]);
      if (id != 0 && int'(hdr[15:0]) == id) begin hit = cur; break; end
      if (nx == 0) begin hit = 0; prev = cur; break; end
      if (nx < 256 || nx > 4088) begin e = 1; break; end
      if (h == MAXH) begin e = 1; break; end
      prev = cur;
      cur = nx;
    end
  endtask

  task automatic run_op(input bit app, input int id, input int ver, input int off,
                        input int size, input string req);
    int ehit, eprev, h, n, lat, tail, nm;
    bit ee, empty;
    logic [31:0] hdr;
    ehit = 0; eprev = 0; ee = 0;
    n = (size + 3) / 4;
    if (!app) begin
      model_walk(id, ehit, eprev, h, ee, empty);
      lat = 1 + 2 * h;
    end else if ((off % 4) != 0 || off < 256 || off > 4088 || size < 8) begin
      ee = 1; lat = 1;
    end else if (off == 256) begin
      hdr = mm[64];
      mm[64] = {hdr[31:20], 4'(ver), 16'(id)};
      for (int i = 0; i < n; i++) mk[(64 + i) % 1024] = 1'b0;
      ehit = 256; eprev = 0; lat = 4 + n;
    end else begin
      model_walk(0, ehit, tail, h, ee, empty);
      if (empty) begin
        ee = 1; lat = 3;
      end else if (ee) begin
        lat = 1 + 2 * h;
      end else begin
        hdr = mm[tail / 4];
        mm[tail / 4] = {12'(off), hdr[19:0]};
        mm[off / 4] = {12'h000, 4'(ver), 16'(id)};
        for (int i = 0; i < n; i++) mk[(off / 4 + i) % 1024] = 1'b0;
        ehit = off; eprev = tail; lat = 2 * h + 3 + n;
      end
    end
    @(negedge clk);
    start = 1'b1; op_append = app; req_id = 16'(id); new_ver = 4'(ver);
    new_off = 12'(off); new_size = 13'(size);
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      check(done == (k == lat), req, $sformatf("done at cycle %0d", k), done, (k == lat));
      if (k == lat) begin
        check(err == ee, req, "err", err, ee);
        if (!ee) begin
          check(hit_off == 12'(ehit), req, "hit_off", hit_off, ehit);
          check(prev_off == 12'(eprev), req, "prev_off", prev_off, eprev);
        end
      end
    end
    nm = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== mm[i] || mbit[i] !== mk[i]) nm++;
    check(nm == 0, req, "ram/mask image mismatching words", nm, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL R7 watchdog: actual no completion expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_append = 1'b0; req_id = '0; new_ver = '0;
    new_off = '0; new_size = '0; init_all = 1'b1; poke_en = 1'b0; poke_a = '0; poke_d = '0;
    for (int i = 0; i < 1024; i++) begin mm[i] = '0; mk[i] = 1'b1; end
    repeat (3) @(negedge clk);
    init_all = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(!done && !err, "R7", "reset done/err", {done, err}, 0);
    check(!mem_rd && !mem_wr && !mask_clr, "R1", "reset strobes", {mem_rd, mem_wr, mask_clr}, 0);

    run_op(0, 16'h0010, 0, 0, 0, "R3");
    run_op(1, 16'h0001, 1, 12'h100, 16, "R8");
    run_op(1, 16'h000E, 2, 12'h140, 8, "R9");
    run_op(1, 16'h0018, 3, 12'h200, 12, "R10");
    run_op(0, 16'h000E, 0, 0, 0, "R2");
    run_op(0, 16'h0001, 0, 0, 0, "R2");
    run_op(0, 16'h0018, 0, 0, 0, "R1");
    run_op(0, 16'h1234, 0, 0, 0, "R4");
    run_op(0, 16'h0000, 0, 0, 0, "R4");
    run_op(1, 16'h0005, 1, 12'h302, 16, "R11");
    run_op(1, 16'h0005, 1, 12'h080, 16, "R11");
    run_op(1, 16'h0005, 1, 12'hFFC, 16, "R11");
    run_op(1, 16'h0005, 1, 12'h300, 4, "R11");
    run_op(1, 16'h0023, 7, 12'h100, 20, "R8");
    run_op(0, 16'h0018, 0, 0, 0, "R2");
    run_op(1, 16'h0025, 1, 12'hFF8, 8, "R10");

    poke(12'h200, {12'h0F0, 4'h3, 16'h0018});
    run_op(0, 16'h9999, 0, 0, 0, "R5");
    poke(12'h200, {12'hFFC, 4'h3, 16'h0018});
    run_op(0, 16'h9999, 0, 0, 0, "R5");
    run_op(1, 16'h0031, 1, 12'h400, 8, "R5");
    poke(12'h200, {12'h140, 4'h3, 16'h0018});
    run_op(0, 16'h7777, 0, 0, 0, "R6");
    run_op(0, 16'h000E, 0, 0, 0, "R6");

    wipe();
    run_op(1, 16'h0040, 1, 12'h300, 8, "R11");
    run_op(0, 16'h0000, 0, 0, 0, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule